// File: doc/BRIEF.md
# Decimal Digit-Pair Integer Square Root

This block returns the integer square root, floor(sqrt(x)), of a 32-bit unsigned operand. It uses the long-hand decimal method. The operand is viewed as a run of two-digit base-100 groups. The result gains one decimal digit per group, starting at the most significant group. The leading digit comes from a single comparison step against fixed thresholds. Each later digit is found by trial: candidates run from 9 down to 0, one per clock, and the first one whose growth term fits in the running remainder is kept.

A request is a one-cycle `start` pulse while `ready` is high, with the operand on `operand` in the same cycle. The block handles one operand at a time. When the root is available it pulses `done` for one cycle, and `root` keeps that value until the next result is written. The number of digit steps follows from the operand's size. The run also ends early when the remainder becomes zero.

Top module: `sqrt_dp_root`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `ready` is 1, `done` is 0 and `root` is 0.
- R2: `start` is taken only in a cycle where `ready` is 1. From the next cycle on, `ready` stays 0 until the result is delivered. A `start` pulse seen while `ready` is 0 has no effect on the operand or on the result.
- R3: `done` is high for exactly one cycle per accepted request, and `ready` is 1 again in the cycle after `done`.
- R4: When `done` is high, `root` equals floor(sqrt(x)) for the operand x that was accepted, for every x from 0 to 4294967295. Examples: 64009 gives 253, 99 gives 9, and 4294967295 gives 65535.
- R5: `root` changes only in a cycle where `done` is high. Between results it holds its value, whatever `operand` and `start` do.
- R6: The leading root digit comes from the leading group g in one step: 9 for g ≥ 81, 8 for g ≥ 64, 7 for g ≥ 49, 6 for g ≥ 36, 5 for g ≥ 25, 4 for g ≥ 16, 3 for g ≥ 9, 2 for g ≥ 4, 1 for g ≥ 1, otherwise 0. For any operand from 0 to 99 there is only one group, so `done` rises after the second rising edge counted from the edge that accepted `start`.
- R7: The group count G is 1 for operands below 100, 2 below 10^4, 3 below 10^6, 4 below 10^8, and 5 otherwise. Each digit after the first takes one cycle per candidate tried, counting down from 9. `done` therefore rises at most 2 + 10·(G−1) edges after the accepting edge. For 64009 it rises after exactly 14 edges.
- R8: When subtracting the square of the leading part leaves a zero remainder, the run ends at once with the remaining digits zero. For example, 6400, 40000 and 250000 finish after 2 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, taken while `ready` is 1 |
| operand | input | 32 | Unsigned value whose root is wanted, sampled with `start` |
| ready | output | 1 | High while idle and able to accept a request |
| done | output | 1 | One-cycle pulse marking a new value on `root` |
| root | output | 16 | Integer square root of the last accepted operand |

## Verification
A wrong leading digit or a wrong group count gives a root that is off by a whole power of ten. This shows in the cycle `done` rises, and it also changes how many edges the run takes. A trial step that accepts a candidate too early or too late gives a root whose square exceeds the operand, or whose successor's square does not. Such roots are caught against an independently computed floor root on perfect squares, on values one below them, and on random operands. A fault in the remainder or in the early-stop path shows up either as a latency different from the one expected for squares such as 40000, or as a run that exceeds the 2 + 10·(G−1) edge bound.

// File: rtl/sqrt_dp_pkg.sv
package sqrt_dp_pkg;

    localparam int OP_W = 32;
    localparam int RT_W = OP_W / 2;
    localparam int CW   = OP_W + 8;
    localparam int DG_W = 4;

    typedef logic [CW-1:0] wide_t;

    // decimal digits needed for the largest operand
    function automatic int dec_digits(input int bits);
        logic [63:0] v;
        int          n;
        v = (64'd1 << bits) - 64'd1;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            if (v != 64'd0) begin
                v = v / 64'd10;
                n++;
            end
        end
        return n;
    endfunction

    localparam int NGRP    = (dec_digits(OP_W) + 1) / 2;
    localparam int KW      = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int LAT_MAX = 2 + 10 * (NGRP - 1);

    function automatic wide_t pow10(input int k);
        wide_t p;
        p = wide_t'(1);
        for (int i = 0; i < 2 * NGRP; i++) begin
            if (i < k) p = p * wide_t'(10);
        end
        return p;
    endfunction

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_TRIAL = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [OP_W-1:0] rem;
        logic [RT_W-1:0] acc;
        logic [KW-1:0]   kidx;
        logic [DG_W-1:0] dig;
    } work_t;

endpackage

// File: rtl/sqrt_dp_span.sv
module sqrt_dp_span
    import sqrt_dp_pkg::*;
(
    input  logic [OP_W-1:0] opnd,
    output logic [KW-1:0]   top_k,
    output logic [DG_W-1:0] lead_dig,
    output logic [RT_W-1:0] lead_val,
    output logic [OP_W-1:0] lead_sq
);

    wide_t           w_tab [NGRP];
    logic [NGRP-1:0] above;
    logic [KW:0]     grp_cnt;
    wide_t           w_sel;
    logic [9:1]      hit;
    wide_t           lv_w;
    wide_t           sq_w;

    // constant weight table and group presence flags
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign w_tab[g] = pow10(g);
        if (g == 0) begin : g_first
            assign above[g] = 1'b1;
        end else begin : g_rest
            assign above[g] = wide_t'(opnd) >= pow10(2 * g);
        end
    end

    always_comb begin
        grp_cnt = '0;
        for (int g = 0; g < NGRP; g++) begin
            grp_cnt = grp_cnt + (KW+1)'(above[g]);
        end
        top_k = KW'(grp_cnt - (KW+1)'(1));
    end

    always_comb begin
        w_sel = w_tab[0];
        for (int g = 0; g < NGRP; g++) begin
            if (KW'(g) == top_k) w_sel = w_tab[g];
        end
    end

    // leading-group thresholds: candidate d fits when (d*w)^2 <= operand
    for (genvar d = 1; d <= 9; d++) begin : g_thr
        wide_t dw;
        wide_t dw_sq;
        assign dw     = w_sel * wide_t'(d);
        assign dw_sq  = dw * dw;
        assign hit[d] = wide_t'(opnd) >= dw_sq;
    end

    always_comb begin
        lead_dig = '0;
        for (int d = 1; d <= 9; d++) begin
            lead_dig = lead_dig + DG_W'(hit[d]);
        end
    end

    assign lv_w     = w_sel * wide_t'(lead_dig);
    assign sq_w     = lv_w * lv_w;
    assign lead_val = lv_w[RT_W-1:0];
    assign lead_sq  = sq_w[OP_W-1:0];

    logic unused_span_hi;
    assign unused_span_hi = ^{lv_w[CW-1:RT_W], sq_w[CW-1:OP_W]};

endmodule

// File: rtl/sqrt_dp_trial.sv
module sqrt_dp_trial
    import sqrt_dp_pkg::*;
(
    input  logic [RT_W-1:0] acc,
    input  logic [DG_W-1:0] dig,
    input  logic [KW-1:0]   kidx,
    input  logic [OP_W-1:0] rem,
    output logic            fits,
    output logic [OP_W-1:0] rem_next,
    output logic [RT_W-1:0] acc_next
);

    wide_t w_tab [NGRP];
    wide_t w_sel;
    wide_t bw;
    wide_t span;
    wide_t cost;

    for (genvar g = 0; g < NGRP; g++) begin : g_w
        assign w_tab[g] = pow10(g);
    end

    always_comb begin
        w_sel = w_tab[0];
        for (int g = 0; g < NGRP; g++) begin
            if (KW'(g) == kidx) w_sel = w_tab[g];
        end
    end

    // growth term b*w*(2*acc + b*w) through one shared product
    assign bw       = w_sel * wide_t'(dig);
    assign span     = (wide_t'(acc) << 1) + bw;
    assign cost     = bw * span;
    assign fits     = cost <= wide_t'(rem);
    assign rem_next = rem - cost[OP_W-1:0];
    assign acc_next = acc + bw[RT_W-1:0];

    logic unused_trial_hi;
    assign unused_trial_hi = ^{bw[CW-1:RT_W], cost[CW-1:OP_W]};

endmodule

// File: rtl/sqrt_dp_ctrl.sv
module sqrt_dp_ctrl
    import sqrt_dp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] operand,
    input  logic [KW-1:0]   top_k,
    input  logic [RT_W-1:0] lead_val,
    input  logic [OP_W-1:0] lead_sq,
    input  logic            fits,
    input  logic [OP_W-1:0] rem_next,
    input  logic [RT_W-1:0] acc_next,
    output logic [OP_W-1:0] opnd_q,
    output work_t           wk,
    output logic            ready,
    output logic            done,
    output logic [RT_W-1:0] root
);

    phase_e          phase;
    logic [RT_W-1:0] root_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            opnd_q <= '0;
            wk     <= '0;
            root_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        opnd_q <= operand;
                        phase  <= PH_LEAD;
                    end
                end
                PH_LEAD: begin
                    wk.acc <= lead_val;
                    wk.rem <= opnd_q - lead_sq;
                    wk.dig <= DG_W'(9);
                    if (top_k == '0 || opnd_q == lead_sq) begin
                        root_q <= lead_val;
                        phase  <= PH_DONE;
                    end else begin
                        wk.kidx <= top_k - KW'(1);
                        phase   <= PH_TRIAL;
                    end
                end
                PH_TRIAL: begin
                    if (fits) begin
                        wk.acc <= acc_next;
                        wk.rem <= rem_next;
                        wk.dig <= DG_W'(9);
                        if (wk.kidx == '0 || rem_next == '0) begin
                            root_q <= acc_next;
                            phase  <= PH_DONE;
                        end else begin
                            wk.kidx <= wk.kidx - KW'(1);
                        end
                    end else begin
                        wk.dig <= wk.dig - DG_W'(1);
                    end
                end
                PH_DONE: begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign ready = (phase == PH_IDLE);
    assign done  = (phase == PH_DONE);
    assign root  = root_q;

endmodule

// File: rtl/sqrt_dp_root.sv
module sqrt_dp_root
    import sqrt_dp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [31:0]     operand,
    output logic            ready,
    output logic            done,
    output logic [15:0]     root
);

    logic [OP_W-1:0] opnd_q;
    work_t           wk;
    logic [KW-1:0]   top_k;
    logic [DG_W-1:0] lead_dig;
    logic [RT_W-1:0] lead_val;
    logic [OP_W-1:0] lead_sq;
    logic            fits;
    logic [OP_W-1:0] rem_next;
    logic [RT_W-1:0] acc_next;

    sqrt_dp_span u_span (
        .opnd     (opnd_q),
        .top_k    (top_k),
        .lead_dig (lead_dig),
        .lead_val (lead_val),
        .lead_sq  (lead_sq)
    );

    sqrt_dp_trial u_trial (
        .acc      (wk.acc),
        .dig      (wk.dig),
        .kidx     (wk.kidx),
        .rem      (wk.rem),
        .fits     (fits),
        .rem_next (rem_next),
        .acc_next (acc_next)
    );

    sqrt_dp_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .operand  (operand),
        .top_k    (top_k),
        .lead_val (lead_val),
        .lead_sq  (lead_sq),
        .fits     (fits),
        .rem_next (rem_next),
        .acc_next (acc_next),
        .opnd_q   (opnd_q),
        .wk       (wk),
        .ready    (ready),
        .done     (done),
        .root     (root)
    );

    logic unused_lead_dig;
    assign unused_lead_dig = ^lead_dig;

endmodule

// File: rtl/sqrt_dp_root_chk.sv
module sqrt_dp_root_chk
    import sqrt_dp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [31:0] operand,
    input logic        ready,
    input logic        done,
    input logic [15:0] root
);

    logic [31:0] cap;
    logic [7:0]  cnt;
    logic [63:0] sq_lo;
    logic [63:0] sq_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
            cnt <= '0;
        end else if (start && ready) begin
            cap <= operand;
            cnt <= 8'd1;
        end else if (done) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt + 8'd1;
        end
    end

    assign sq_lo = {48'd0, root} * {48'd0, root};
    assign sq_hi = ({48'd0, root} + 64'd1) * ({48'd0, root} + 64'd1);

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ready && !done && root == 16'd0));

    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (start && ready) |=> !ready);

    a_r2_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        (!ready && !done) |=> !ready);

    a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && ready));

    a_r4_floor_root: assert property (@(posedge clk) disable iff (rst)
        done |-> (sq_lo <= {32'd0, cap} && sq_hi > {32'd0, cap}));

    a_r5_root_held: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(root));

    a_r6_single_group_fast: assert property (@(posedge clk) disable iff (rst)
        (done && cap < 32'd100) |-> (cnt == 8'd2));

    a_r7_latency_bound: assert property (@(posedge clk) disable iff (rst)
        (cnt != 8'd0) |-> (int'(cnt) <= LAT_MAX));

endmodule

bind sqrt_dp_root sqrt_dp_root_chk u_chk (.*);

// File: tb/sqrt_dp_root_bench.sv
`timescale 1ns/1ps
module sqrt_dp_root_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic        ready;
    logic        done;
    logic [15:0] root;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sqrt_dp_root u_sqrt_dp_root (.*);

    function automatic logic [15:0] ref_root(input logic [31:0] x);
        logic [63:0] r;
        logic [63:0] t;
        r = '0;
        for (int b = 15; b >= 0; b--) begin
            t = r | (64'd1 << b);
            if (t * t <= {32'd0, x}) r = t;
        end
        return r[15:0];
    endfunction

    function automatic int groups_of(input logic [31:0] x);
        int          g;
        logic [63:0] lim;
        g   = 1;
        lim = 64'd100;
        for (int i = 0; i < 4; i++) begin
            if ({32'd0, x} >= lim) begin
                g++;
                lim = lim * 64'd100;
            end
        end
        return g;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // one request; lat counts edges from the accepting edge to done
    task automatic run_op(input logic [31:0] x, input bit poke,
                          output logic [15:0] r, output int lat);
        @(negedge clk);
        chk(ready == 1'b1, "R2", "ready before start", longint'(ready), 1);
        operand = x;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        while (!done && lat < 200) begin
            chk(ready == 1'b0, "R2", "ready while busy", longint'(ready), 0);
            if (poke && lat == 3) begin
                start   = 1'b1;
                operand = 32'd1;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        chk(done == 1'b1, "R7", "run finished", longint'(lat), 200);
        r = root;
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R3", "done single cycle", longint'(done), 0);
        chk(ready == 1'b1, "R3", "ready after done", longint'(ready), 1);
    endtask

    task automatic run_check(input logic [31:0] x);
        logic [15:0] r;
        int          lat;
        int          bound;
        run_op(x, 1'b0, r, lat);
        chk(r == ref_root(x), "R4", $sformatf("root of %0d", x),
            longint'(r), longint'(ref_root(x)));
        bound = 2 + 10 * (groups_of(x) - 1);
        chk(lat <= bound, "R7", $sformatf("latency of %0d", x),
            longint'(lat), longint'(bound));
    endtask

    initial begin
        #4000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        logic [15:0] r;
        int          lat;
        logic [31:0] x;
        int          s_list [13] = '{1, 2, 3, 10, 31, 99, 100, 101, 999,
                                     1000, 9999, 10000, 65535};
        void'($urandom(32'd7001));

        repeat (3) @(negedge clk);
        chk(ready == 1'b1 && done == 1'b0 && root == 16'd0, "R1", "state in reset",
            longint'({ready, done, root}), longint'({1'b1, 1'b0, 16'd0}));
        rst = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1 && done == 1'b0 && root == 16'd0, "R1", "state after reset",
            longint'({ready, done, root}), longint'({1'b1, 1'b0, 16'd0}));

        // R6: single-group operands, threshold digit, two edges
        for (int v = 0; v < 100; v++) begin
            run_op(32'(v), 1'b0, r, lat);
            chk(r == ref_root(32'(v)), "R6", $sformatf("lead digit of %0d", v),
                longint'(r), longint'(ref_root(32'(v))));
            chk(lat == 2, "R6", $sformatf("latency of %0d", v), longint'(lat), 2);
        end

        // R4 and R7: worked example with exact latency
        run_op(32'd64009, 1'b0, r, lat);
        chk(r == 16'd253, "R4", "root of 64009", longint'(r), 253);
        chk(lat == 14, "R7", "latency of 64009", longint'(lat), 14);

        run_check(32'hFFFF_FFFF);
        run_check(32'd99);
        run_check(32'd100);

        // R8: zero remainder after the leading digit
        run_op(32'd6400, 1'b0, r, lat);
        chk(r == 16'd80, "R8", "root of 6400", longint'(r), 80);
        chk(lat == 2, "R8", "latency of 6400", longint'(lat), 2);
        run_op(32'd40000, 1'b0, r, lat);
        chk(r == 16'd200, "R8", "root of 40000", longint'(r), 200);
        chk(lat == 2, "R8", "latency of 40000", longint'(lat), 2);
        run_op(32'd250000, 1'b0, r, lat);
        chk(r == 16'd500, "R8", "root of 250000", longint'(r), 500);
        chk(lat == 2, "R8", "latency of 250000", longint'(lat), 2);

        // R4: perfect squares and one below each
        foreach (s_list[i]) begin
            x = 32'(s_list[i]) * 32'(s_list[i]);
            run_check(x);
            run_check(x - 32'd1);
        end

        // R2: start while busy is ignored
        run_op(32'd64009, 1'b1, r, lat);
        chk(r == 16'd253, "R2", "root with start while busy", longint'(r), 253);
        chk(lat == 14, "R2", "latency with start while busy", longint'(lat), 14);

        // R5: root holds while idle and operand moves
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            operand = $urandom;
            chk(root == 16'd253 && done == 1'b0, "R5", "root held while idle",
                longint'(root), 253);
        end

        // R4/R7: random mix
        for (int i = 0; i < 300; i++) begin
            logic [15:0] s;
            s = 16'($urandom);
            case ($urandom % 4)
                0: x = $urandom;
                1: x = $urandom % 10000;
                2: x = 32'(s) * 32'(s);
                default: x = (s == 16'd0) ? 32'd0 : 32'(s) * 32'(s) - 32'd1;
            endcase
            run_check(x);
        end

        summary();
    end

endmodule